// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Gate Sequencer

This block generates the high-side and low-side switch enables for two buck converter phases from a single counter-based time base. The period input sets the switching period in clocks. The second phase's period begins half a period after the first, so the two phases run in antiphase. Each phase takes its own on-time command in clocks and captures it once, at the start of that phase's period. The high-side on-time is clamped to three quarters of the period. A programmable dead time keeps both switches of a phase off between every turn-off and the next turn-on of the opposite switch.

Each phase has its own overcurrent flag. While the flag is high, that phase turns its high-side switch off, keeps its low-side switch on and drops whole switching cycles. The other phase carries on unaffected. Once the flag clears, high-side switching resumes only at that phase's next period start. A fault input latches until reset and forces both low-side switches on and both high-side switches off. A disable input removes all four enables at once and overrides everything else. Intended settings: an even period of at least 8 clocks, a dead time below one eighth of the period, and a period and dead time that change only while reset is asserted.

Top module: `dual_phase_pwm`

## Requirements
- R1: While rst is high all four enables are low. After rst falls, the timer starts at zero and phase 0's high-side enable first rises on the (dead+1)-th clock.
- R2: For equal on-time commands, phase 1's high-side enable rises exactly period/2 clocks after phase 0's.
- R3: A high-side pulse lasts exactly the commanded number of clocks when the command is at most floor(3*period/4).
- R4: A command above floor(3*period/4) yields a pulse of exactly floor(3*period/4) clocks.
- R5: The on-time command is captured only at the phase's period start. A change made during a pulse first affects the following period.
- R6: Within one phase, hs_o[i] and ls_o[i] are never high together. Exactly `dead` clocks with both low separate each high-side turn-off from the next low-side turn-on, and each low-side turn-off from the next high-side turn-on.
- R7: When oc_i[i] is sampled high, hs_o[i] is low from the next clock. ls_o[i] turns on after the dead time and stays on, with no high-side pulse, for as long as the flag stays high.
- R8: After oc_i[i] falls, hs_o[i] stays low until the phase's next period start and then gives a pulse of the commanded width.
- R9: The overcurrent flag of one phase leaves the other phase's pulses unchanged.
- R10: From the clock after fault_i is sampled high, hs_o is 2'b00 and ls_o is 2'b11. This holds after fault_i falls and lasts until reset.
- R11: While disable_i is high, all four enables are low in the same cycle, including during a latched fault.
- R12: An on-time command of zero produces no high-side pulse, and the low-side enable of that phase stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Switching period in clocks |
| dead_i | input | DEAD_W | Dead time in clocks |
| duty_i | input | 2 x CNT_W | Per-phase high-side on-time command in clocks |
| oc_i | input | 2 | Per-phase overcurrent flag |
| fault_i | input | 1 | Overvoltage fault, latched internally |
| disable_i | input | 1 | Turns every switch off |
| hs_o | output | 2 | High-side enables, bit i for phase i |
| ls_o | output | 2 | Low-side enables, bit i for phase i |

## Verification
Several command pairs are applied: equal, unequal, one exactly at the clamp, one above it, and zero. Together they separate correct pulse widths from a wrong clamp, a swapped phase and a missing zero case. The offset between the two phases' rising edges separates antiphase timing from in-phase timing. A command changed during a live pulse distinguishes capture at the period start from continuous sampling. An overcurrent flag raised during a pulse and then cleared at a known offset shows the cut-off time, the dropped cycles, the resume point at the next period start, and the fact that the other phase is untouched. Dead-time gaps are measured on every switch transition.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int NPH = 2;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_DEAD_UP,
        PH_HIGH,
        PH_DEAD_DN,
        PH_LOW
    } ph_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    function automatic gate_t decode_gate(ph_state_e s);
        gate_t g;
        g.hs = (s == PH_HIGH);
        g.ls = (s == PH_LOW);
        return g;
    endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    output logic [NPH-1:0]   start_o
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt >= period_i - CNT_W'(1))
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    // Each phase starts at its share of the period: i * period / NPH.
    for (genvar i = 0; i < NPH; i++) begin : g_off
        logic [CNT_W+1:0] prod;
        logic [CNT_W-1:0] off;
        always_comb begin
            prod = (CNT_W+2)'(period_i) * (CNT_W+2)'(i);
            off  = CNT_W'(prod / (CNT_W+2)'(NPH));
        end
        assign start_o[i] = (cnt == off);
    end

    // R2: the two phase starts fall in different cycles
    assert_single_start_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_o));

endmodule

// File: rtl/dpwm_phase.sv
module dpwm_phase
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              oc_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [DEAD_W-1:0] dead_i,
    output gate_t             gate_o
);

    ph_state_e        st, st_n;
    logic [CNT_W-1:0] tmr, tmr_n;
    logic [CNT_W-1:0] len_q, len;
    logic [CNT_W+1:0] cap_wide;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] dead_ext;

    always_comb begin
        cap_wide = ({2'b00, period_i} * (CNT_W+2)'(3)) >> 2;
        cap      = cap_wide[CNT_W-1:0];
        len      = (duty_i > cap) ? cap : duty_i;
        dead_ext = CNT_W'(dead_i);
    end

    always_comb begin
        st_n  = st;
        tmr_n = tmr;
        if (start_i) begin
            if (oc_i || len == '0) begin
                st_n = PH_LOW;
            end else if (dead_i == '0) begin
                st_n  = PH_HIGH;
                tmr_n = len;
            end else begin
                st_n  = PH_DEAD_UP;
                tmr_n = dead_ext;
            end
        end else begin
            case (st)
                PH_DEAD_UP: begin
                    if (oc_i) begin
                        st_n = PH_LOW;
                    end else if (tmr <= CNT_W'(1)) begin
                        st_n  = PH_HIGH;
                        tmr_n = len_q;
                    end else begin
                        tmr_n = tmr - CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (oc_i || tmr <= CNT_W'(1)) begin
                        if (dead_i == '0) begin
                            st_n = PH_LOW;
                        end else begin
                            st_n  = PH_DEAD_DN;
                            tmr_n = dead_ext;
                        end
                    end else begin
                        tmr_n = tmr - CNT_W'(1);
                    end
                end
                PH_DEAD_DN: begin
                    if (tmr <= CNT_W'(1))
                        st_n = PH_LOW;
                    else
                        tmr_n = tmr - CNT_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_OFF;
            tmr   <= '0;
            len_q <= '0;
        end else begin
            st  <= st_n;
            tmr <= tmr_n;
            if (start_i)
                len_q <= len;
        end
    end

    assign gate_o = decode_gate(st);

    // checker: length of the current high-side run
    logic [CNT_W-1:0] hs_run;
    always_ff @(posedge clk) begin
        if (rst)
            hs_run <= '0;
        else if (st_n == PH_HIGH)
            hs_run <= hs_run + CNT_W'(1);
        else
            hs_run <= '0;
    end

    // R4: no high-side run exceeds three quarters of the period
    assert_high_cap_R4: assert property (@(posedge clk) disable iff (rst)
        hs_run <= cap);

    // R7: an overcurrent flag removes the high side on the next clock
    assert_oc_cuts_high_R7: assert property (@(posedge clk) disable iff (rst)
        oc_i |=> !gate_o.hs);

    // R8: the high side never rises right after a sampled overcurrent flag
    assert_resume_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o.hs) |-> !$past(oc_i));

endmodule

// File: rtl/dpwm_guard.sv
module dpwm_guard
    import dpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fault_i,
    input  logic                disable_i,
    input  gate_t [NPH-1:0]     gate_i,
    output logic  [NPH-1:0]     hs_o,
    output logic  [NPH-1:0]     ls_o
);

    logic fault_lat;

    always_ff @(posedge clk) begin
        if (rst)
            fault_lat <= 1'b0;
        else if (fault_i)
            fault_lat <= 1'b1;
    end

    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            if (disable_i) begin
                hs_o[i] = 1'b0;
                ls_o[i] = 1'b0;
            end else if (fault_lat) begin
                hs_o[i] = 1'b0;
                ls_o[i] = 1'b1;
            end else begin
                hs_o[i] = gate_i[i].hs;
                ls_o[i] = gate_i[i].ls;
            end
        end
    end

    // R6: no phase drives both switches together
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        (hs_o & ls_o) == '0);

    // R10: a fault forces every low side on from the next clock
    assert_fault_force_R10: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (disable_i || (hs_o == '0 && ls_o == '1)));

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          period_i,
    input  logic [DEAD_W-1:0]         dead_i,
    input  logic [1:0][CNT_W-1:0]     duty_i,
    input  logic [1:0]                oc_i,
    input  logic                      fault_i,
    input  logic                      disable_i,
    output logic [1:0]                hs_o,
    output logic [1:0]                ls_o
);

    logic  [NPH-1:0] start;
    gate_t [NPH-1:0] gate;

    dpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .start_o  (start)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        dpwm_phase #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_ph (
            .clk      (clk),
            .rst      (rst),
            .start_i  (start[i]),
            .oc_i     (oc_i[i]),
            .duty_i   (duty_i[i]),
            .period_i (period_i),
            .dead_i   (dead_i),
            .gate_o   (gate[i])
        );
    end

    dpwm_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault_i),
        .disable_i (disable_i),
        .gate_i    (gate),
        .hs_o      (hs_o),
        .ls_o      (ls_o)
    );

endmodule

// File: tb/dual_phase_pwm_test.sv
`timescale 1ns/1ps
module dual_phase_pwm_test;

    localparam int CW = 12;
    localparam int DW = 6;
    localparam int P  = 40;
    localparam int CAP = (P * 3) / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] period = CW'(P);
    logic [DW-1:0] dead = DW'(4);
    logic [1:0][CW-1:0] duty;
    logic [1:0] oc = 2'b00;
    logic fault = 1'b0;
    logic dis = 1'b0;
    logic [1:0] hs_o, ls_o;

    always #2 clk = ~clk;

    dual_phase_pwm #(.CNT_W(CW), .DEAD_W(DW)) uut (
        .clk(clk), .rst(rst), .period_i(period), .dead_i(dead),
        .duty_i(duty), .oc_i(oc), .fault_i(fault), .disable_i(dis),
        .hs_o(hs_o), .ls_o(ls_o)
    );

    typedef struct { int w; string tag; } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    int vectors = 0;
    int errors = 0;
    int overlap_cnt = 0;
    bit gap_on = 1'b0;
    int run [2] = '{0, 0};
    int gap [2] = '{0, 0};
    int last [2] = '{0, 0};

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(int p, int w, string tag, int n);
        exp_t e;
        e.w = w;
        e.tag = tag;
        for (int k = 0; k < n; k++) begin
            if (p == 0) q0.push_back(e);
            else q1.push_back(e);
        end
    endtask

    // monitor: pops expected widths at the end of each high-side pulse
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < 2; p++) begin
                exp_t e;
                int cur;
                if (hs_o[p] && ls_o[p]) overlap_cnt++;
                if (hs_o[p]) begin
                    run[p]++;
                end else if (run[p] != 0) begin
                    if (p == 0 && q0.size() > 0) begin
                        e = q0.pop_front();
                        chk(run[p] == e.w, e.tag, "phase0 pulse width", run[p], e.w);
                    end else if (p == 1 && q1.size() > 0) begin
                        e = q1.pop_front();
                        chk(run[p] == e.w, e.tag, "phase1 pulse width", run[p], e.w);
                    end
                    run[p] = 0;
                end
                if (!gap_on) last[p] = 0;
                if (hs_o[p] || ls_o[p]) begin
                    cur = hs_o[p] ? 1 : 2;
                    if (gap_on && last[p] != 0 && last[p] != cur)
                        chk(gap[p] == int'(dead), "R6", "dead-time gap", gap[p], int'(dead));
                    last[p] = cur;
                    gap[p] = 0;
                end else begin
                    gap[p]++;
                end
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(int p);
        while (hs_o[p]) @(negedge clk);
        do @(negedge clk); while (!hs_o[p]);
    endtask

    task automatic count_to_rise(int p, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_o[p] && n < 4 * P);
    endtask

    task automatic run_case(int d0, int d1, int n, string t0, string t1);
        duty[0] = CW'(d0);
        duty[1] = CW'(d1);
        q0.delete();
        q1.delete();
        wait_cyc(2 * P);
        push_exp(0, (d0 > CAP) ? CAP : d0, t0, n);
        push_exp(1, (d1 > CAP) ? CAP : d1, t1, n);
        wait_cyc((n + 1) * P);
        chk(q0.size() == 0, t0, "phase0 pulses missing", q0.size(), 0);
        chk(q1.size() == 0, t1, "phase1 pulses missing", q1.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int n;
        int bad;
        duty[0] = CW'(10);
        duty[1] = CW'(10);
        wait_cyc(3);
        chk(hs_o == 2'b00 && ls_o == 2'b00, "R1", "enables in reset", {hs_o, ls_o}, 0);
        rst = 1'b0;
        count_to_rise(0, n);
        chk(n == 5, "R1", "first high-side rise after reset", n, 5);
        gap_on = 1'b1;

        // antiphase offset
        wait_rise(0);
        count_to_rise(1, n);
        chk(n == P / 2, "R2", "phase offset", n, P / 2);

        run_case(10, 10, 3, "R3", "R3");
        run_case(25, 7, 3, "R3", "R3");
        run_case(35, CAP, 3, "R4", "R3");
        run_case(P - 1, 1, 2, "R4", "R3");

        // mid-pulse command change
        duty[0] = CW'(10);
        duty[1] = CW'(10);
        wait_cyc(2 * P);
        q0.delete();
        q1.delete();
        wait_rise(0);
        push_exp(0, 10, "R5", 1);
        push_exp(0, 28, "R5", 2);
        duty[0] = CW'(28);
        wait_cyc(4 * P);
        chk(q0.size() == 0, "R5", "phase0 pulses missing", q0.size(), 0);

        // zero command
        duty[0] = CW'(0);
        duty[1] = CW'(12);
        wait_cyc(2 * P);
        bad = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (hs_o[0] || !ls_o[0]) bad++;
        end
        chk(bad == 0, "R12", "cycles with phase0 high side on", bad, 0);

        // overcurrent on phase 0
        duty[0] = CW'(15);
        duty[1] = CW'(12);
        wait_cyc(2 * P);
        q0.delete();
        q1.delete();
        push_exp(1, 12, "R9", 3);
        wait_rise(0);
        wait_cyc(2);
        oc[0] = 1'b1;
        @(negedge clk);
        chk(hs_o[0] == 1'b0, "R7", "phase0 high side after flag", hs_o[0], 0);
        wait_cyc(4);
        chk(ls_o[0] == 1'b1, "R7", "phase0 low side after dead time", ls_o[0], 1);
        bad = 0;
        for (int k = 0; k < 2 * P; k++) begin
            @(negedge clk);
            if (hs_o[0] || !ls_o[0]) bad++;
        end
        chk(bad == 0, "R7", "skipped-cycle violations", bad, 0);
        wait_rise(1);
        oc[0] = 1'b0;
        push_exp(0, 15, "R8", 1);
        count_to_rise(0, n);
        chk(n == P / 2, "R8", "clocks from flag clear to resume", n, P / 2);
        wait_cyc(2 * P);
        chk(q0.size() == 0, "R8", "resumed pulse missing", q0.size(), 0);
        chk(q1.size() == 0, "R9", "phase1 pulses missing", q1.size(), 0);

        // shorter dead time
        gap_on = 1'b0;
        wait_cyc(2);
        dead = DW'(2);
        wait_cyc(2 * P);
        gap_on = 1'b1;
        run_case(20, 9, 3, "R3", "R3");

        // disable in normal operation
        gap_on = 1'b0;
        dis = 1'b1;
        #1;
        chk(hs_o == 2'b00 && ls_o == 2'b00, "R11", "enables under disable", {hs_o, ls_o}, 0);
        bad = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (hs_o != 2'b00 || ls_o != 2'b00) bad++;
        end
        chk(bad == 0, "R11", "cycles with an enable on", bad, 0);
        dis = 1'b0;

        // fault latch
        wait_cyc(P);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        chk(hs_o == 2'b00 && ls_o == 2'b11, "R10", "forced enables", {hs_o, ls_o}, 3);
        bad = 0;
        for (int k = 0; k < 2 * P; k++) begin
            @(negedge clk);
            if (hs_o != 2'b00 || ls_o != 2'b11) bad++;
        end
        chk(bad == 0, "R10", "cycles not forced after fault fell", bad, 0);
        dis = 1'b1;
        #1;
        chk(hs_o == 2'b00 && ls_o == 2'b00, "R11", "disable over fault", {hs_o, ls_o}, 0);
        @(negedge clk);
        dis = 1'b0;
        #1;
        chk(hs_o == 2'b00 && ls_o == 2'b11, "R10", "fault still latched", {hs_o, ls_o}, 3);

        // reset clears the fault
        rst = 1'b1;
        dead = DW'(4);
        wait_cyc(2);
        chk(hs_o == 2'b00 && ls_o == 2'b00, "R1", "enables in second reset", {hs_o, ls_o}, 0);
        rst = 1'b0;
        count_to_rise(0, n);
        chk(n == 5, "R10", "switching after reset cleared fault", n, 5);

        chk(overlap_cnt == 0, "R6", "cycles with both switches on", overlap_cnt, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule